// File: doc/BRIEF.md
# Phase Word Modulator with Accumulation

This block forms the phase word that drives a sine/cosine synthesis core. It holds two phase-sized registers, a modulation register and a carrier register. Both load from one shared phase input under a two-bit load code. A two-bit mode selects how the phase word is formed:

- directly, as carrier plus modulation;
- by a running accumulator that implements phase modulation, frequency modulation, or both at once.

All sums are taken modulo 2^W and wrap with no saturation, so the phase runs continuously through a full turn.

Input beats arrive on a valid/ready stream. Each beat carries the phase value, the load code and the mode. Each accepted beat first applies its load code to the registers. It then advances the accumulator using the updated register values, and the resulting phase word is presented on a registered valid/ready output stream one cycle later.

Back-pressure rules:

- `in_ready` is high whenever the output stage is empty or is being drained in the same cycle.
- While an output word is offered and not taken, the block stalls. The registers, the accumulator and the offered word all hold.
- Nothing is dropped and nothing is repeated.

Top module: `phase_mod_acc`

## Requirements
- R1: A synchronous reset clears the modulation register, the carrier register and the accumulator to zero, and clears `out_valid`.
- R2: `in_ready` equals `!out_valid || out_ready`. An input beat is accepted only in a cycle where `in_valid` and `in_ready` are both high.
- R3: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_phase` stays unchanged. No register or accumulator changes while no beat is accepted.
- R4: Load code `in_load` = 2'b00 leaves both registers unchanged.
- R5: Load code 2'b01 loads the modulation register from `in_phase` and leaves the carrier register unchanged.
- R6: Load code 2'b10 loads the carrier register from `in_phase` and leaves the modulation register unchanged.
- R7: Load code 2'b11 clears the modulation register to zero and loads the carrier register from `in_phase`.
- R8: Mode `in_mode` = 2'b00 (bit 1 is the FM enable, bit 0 the PM enable) outputs carrier plus modulation and leaves the accumulator unchanged.
- R9: Mode 2'b01 adds the carrier to the accumulator and outputs the new accumulator plus modulation.
- R10: Mode 2'b10 adds carrier plus modulation to the accumulator and outputs the new accumulator.
- R11: Mode 2'b11 adds carrier plus modulation to the accumulator and outputs the new accumulator plus modulation.
- R12: All additions wrap modulo 2^W; a sum past all-ones continues from zero.
- R13: The word for an accepted beat appears on `out_phase` with `out_valid` high in the next cycle, computed from the register values after that beat's load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input beat present |
| in_ready | output | 1 | Block can accept an input beat |
| in_phase | input | W (32) | Phase value for register loads |
| in_load | input | 2 | Register load code |
| in_mode | input | 2 | Accumulation mode: bit 1 FM, bit 0 PM |
| out_valid | output | 1 | Phase word offered |
| out_ready | input | 1 | Consumer takes the offered word |
| out_phase | output | W (32) | Phase word |

## Verification
The bench aims at the ordering of load and accumulate within a beat. A design that accumulated with the old register values would lag by one load and miss on the first beat after every load. It drives the clear-and-load code right after a modulation load; a design that merely held the modulation register would keep adding the stale offset. Long frequency-accumulation runs from a carrier near all-ones cross the wrap point, where a saturating or sign-extended adder would stick or jump. Random back-pressure checks that a stalled beat neither advances the accumulator twice nor changes the offered word.

// File: rtl/phase_mod_pkg.sv
package phase_mod_pkg;
  typedef enum logic [1:0] {
    LD_HOLD   = 2'b00,
    LD_MOD    = 2'b01,
    LD_CAR    = 2'b10,
    LD_CAR_ZM = 2'b11
  } load_e;

  typedef struct packed {
    logic fm;
    logic pm;
  } mode_t;
endpackage

// File: rtl/phase_mod_regs.sv
module phase_mod_regs
  import phase_mod_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  load_e        ld,
  input  logic [W-1:0] din,
  output logic [W-1:0] m_nxt,
  output logic [W-1:0] c_nxt,
  output logic [W-1:0] m_q,
  output logic [W-1:0] c_q
);
  // Next register contents for the beat being accepted
  always_comb begin
    m_nxt = m_q;
    c_nxt = c_q;
    unique case (ld)
      LD_HOLD:   ;
      LD_MOD:    m_nxt = din;
      LD_CAR:    c_nxt = din;
      LD_CAR_ZM: begin
        m_nxt = '0;
        c_nxt = din;
      end
      default:   ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      m_q <= '0;
      c_q <= '0;
    end else if (fire) begin
      m_q <= m_nxt;
      c_q <= c_nxt;
    end
  end
endmodule

// File: rtl/phase_mod_accum.sv
module phase_mod_accum
  import phase_mod_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  mode_t        mode,
  input  logic [W-1:0] m_val,
  input  logic [W-1:0] c_val,
  output logic [W-1:0] acc_q,
  output logic [W-1:0] word
);
  logic         accum_on;
  logic [W-1:0] step;
  logic [W-1:0] acc_nxt;
  logic [W-1:0] offset;

  assign accum_on = mode.fm | mode.pm;

  // FM accumulates carrier plus modulation; PM accumulates the carrier alone
  assign step    = mode.fm ? (c_val + m_val) : c_val;
  assign acc_nxt = accum_on ? (acc_q + step) : acc_q;

  // PM adds the modulation on top of the running phase
  assign offset  = mode.pm ? m_val : '0;
  assign word    = accum_on ? (acc_nxt + offset) : (c_val + m_val);

  always_ff @(posedge clk) begin
    if (rst)       acc_q <= '0;
    else if (fire) acc_q <= acc_nxt;
  end
endmodule

// File: rtl/phase_mod_ostage.sv
module phase_mod_ostage #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic         out_ready,
  input  logic [W-1:0] word,
  output logic         out_valid,
  output logic [W-1:0] out_phase
);
  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_phase <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_phase <= word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/phase_mod_acc.sv
module phase_mod_acc
  import phase_mod_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_phase,
  input  logic [1:0]   in_load,
  input  logic [1:0]   in_mode,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_phase
);
  logic         fire;
  logic [W-1:0] m_nxt, c_nxt, m_q, c_q, acc_q, word;
  mode_t        mode;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;
  assign mode     = mode_t'(in_mode);

  phase_mod_regs #(.W(W)) u_regs (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .ld    (load_e'(in_load)),
    .din   (in_phase),
    .m_nxt (m_nxt),
    .c_nxt (c_nxt),
    .m_q   (m_q),
    .c_q   (c_q)
  );

  phase_mod_accum #(.W(W)) u_accum (
    .clk   (clk),
    .rst   (rst),
    .fire  (fire),
    .mode  (mode),
    .m_val (m_nxt),
    .c_val (c_nxt),
    .acc_q (acc_q),
    .word  (word)
  );

  phase_mod_ostage #(.W(W)) u_ostage (
    .clk       (clk),
    .rst       (rst),
    .fire      (fire),
    .out_ready (out_ready),
    .word      (word),
    .out_valid (out_valid),
    .out_phase (out_phase)
  );
endmodule

// File: rtl/phase_mod_check.sv
module phase_mod_check #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic         in_ready,
  input logic [W-1:0] in_phase,
  input logic [1:0]   in_load,
  input logic [1:0]   in_mode,
  input logic         out_valid,
  input logic         out_ready,
  input logic [W-1:0] out_phase,
  input logic [W-1:0] m_q,
  input logic [W-1:0] c_q,
  input logic [W-1:0] acc_q
);
  logic acc_beat;
  assign acc_beat = in_valid && in_ready;

  assert_reset_idle_R1: assert property (@(posedge clk)
    rst |=> (!out_valid && m_q == '0 && c_q == '0 && acc_q == '0));

  assert_hold_output_R3: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_phase)));

  assert_stall_state_R3: assert property (@(posedge clk) disable iff (rst)
    !acc_beat |=> ($stable(m_q) && $stable(c_q) && $stable(acc_q)));

  assert_accept_R13: assert property (@(posedge clk) disable iff (rst)
    acc_beat |=> out_valid);

  assert_load_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (acc_beat && in_load == 2'b00) |=> ($stable(m_q) && $stable(c_q)));

  assert_load_mod_R5: assert property (@(posedge clk) disable iff (rst)
    (acc_beat && in_load == 2'b01) |=> (m_q == $past(in_phase) && $stable(c_q)));

  assert_load_car_R6: assert property (@(posedge clk) disable iff (rst)
    (acc_beat && in_load == 2'b10) |=> (c_q == $past(in_phase) && $stable(m_q)));

  assert_load_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (acc_beat && in_load == 2'b11) |=> (m_q == '0 && c_q == $past(in_phase)));

  assert_acc_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (acc_beat && in_mode == 2'b00) |=> $stable(acc_q));
endmodule

bind phase_mod_acc phase_mod_check #(.W(W)) u_check (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_phase  (in_phase),
  .in_load   (in_load),
  .in_mode   (in_mode),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_phase (out_phase),
  .m_q       (m_q),
  .c_q       (c_q),
  .acc_q     (acc_q)
);

// File: tb/tb_phase_mod_acc.sv
`timescale 1ns/1ps
module tb_phase_mod_acc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_phase = '0;
  logic [1:0]  in_load = 2'b00;
  logic [1:0]  in_mode = 2'b00;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_phase;

  int    n_tests = 0;
  int    n_fail  = 0;
  string sect    = "R1";

  always #2.5 clk = ~clk;

  phase_mod_acc dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_phase(in_phase), .in_load(in_load), .in_mode(in_mode),
    .out_valid(out_valid), .out_ready(out_ready), .out_phase(out_phase)
  );

  // Behavioural reference, one update per clock
  logic [31:0] mdl_m = '0, mdl_c = '0, mdl_acc = '0, mdl_out = '0;
  logic        mdl_valid = 1'b0;

  always @(posedge clk) begin
    logic [31:0] nm, nc, na, w;
    if (rst) begin
      mdl_m <= '0; mdl_c <= '0; mdl_acc <= '0; mdl_out <= '0; mdl_valid <= 1'b0;
    end else if (in_valid && (!mdl_valid || out_ready)) begin
      nm = mdl_m; nc = mdl_c; na = mdl_acc;
      if (in_load == 2'b01) nm = in_phase;
      if (in_load == 2'b10) nc = in_phase;
      if (in_load == 2'b11) begin nm = 32'd0; nc = in_phase; end
      if (in_mode == 2'b00) w = nc + nm;
      else if (in_mode == 2'b01) begin na = mdl_acc + nc; w = na + nm; end
      else if (in_mode == 2'b10) begin na = mdl_acc + nc + nm; w = na; end
      else begin na = mdl_acc + nc + nm; w = na + nm; end
      mdl_m <= nm; mdl_c <= nc; mdl_acc <= na; mdl_out <= w; mdl_valid <= 1'b1;
    end else if (out_ready) begin
      mdl_valid <= 1'b0;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Compare outputs, then drive the next cycle's inputs, then check in_ready (R2)
  task automatic step(input logic v, input logic [1:0] ld, input logic [1:0] md,
                      input logic [31:0] ph, input logic rdy);
    @(negedge clk);
    check(out_valid === mdl_valid, {sect, " out_valid"}, {31'd0, out_valid}, {31'd0, mdl_valid});
    if (mdl_valid)
      check(out_phase === mdl_out, {sect, " out_phase"}, out_phase, mdl_out);
    in_valid = v; in_load = ld; in_mode = md; in_phase = ph; out_ready = rdy;
    #1;
    check(in_ready === (!mdl_valid || rdy), "R2 in_ready", {31'd0, in_ready},
          {31'd0, (!mdl_valid || rdy)});
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: idle after reset, then a plain beat outputs zero
    sect = "R1";
    step(0, 2'b00, 2'b00, 32'h0, 1);
    step(1, 2'b00, 2'b00, 32'hDEAD_BEEF, 1);
    step(0, 2'b00, 2'b00, 32'h0, 1);
    sect = "R5";
    step(1, 2'b01, 2'b00, 32'h0000_0100, 1);
    sect = "R6";
    step(1, 2'b10, 2'b00, 32'h0000_0010, 1);
    sect = "R4";
    step(1, 2'b00, 2'b00, 32'h1234_5678, 1);
    step(1, 2'b00, 2'b00, 32'h0BAD_0BAD, 1);
    sect = "R7";
    step(1, 2'b01, 2'b00, 32'h0000_0777, 1);
    step(1, 2'b11, 2'b00, 32'h0000_0020, 1);
    step(1, 2'b00, 2'b00, 32'h0, 1);
    sect = "R8";
    step(1, 2'b01, 2'b00, 32'h0000_0005, 1);
    step(1, 2'b00, 2'b00, 32'h0, 1);
    sect = "R9";
    for (int i = 0; i < 6; i++) step(1, 2'b00, 2'b01, 32'h0, 1);
    step(1, 2'b01, 2'b01, 32'h0000_4000, 1);
    step(1, 2'b00, 2'b01, 32'h0, 1);
    sect = "R10";
    for (int i = 0; i < 6; i++) step(1, 2'b00, 2'b10, 32'h0, 1);
    sect = "R11";
    for (int i = 0; i < 6; i++) step(1, 2'b00, 2'b11, 32'h0, 1);
    step(1, 2'b11, 2'b11, 32'h0000_0100, 1);
    step(1, 2'b00, 2'b11, 32'h0, 1);
    // R12: carrier near all-ones forces the phase past FFFF_FFFF
    sect = "R12";
    step(1, 2'b11, 2'b00, 32'hFFFF_FF00, 1);
    step(1, 2'b01, 2'b00, 32'h0000_0200, 1);
    for (int i = 0; i < 40; i++) step(1, 2'b00, 2'b10, 32'h0, 1);
    for (int i = 0; i < 40; i++) step(1, 2'b00, 2'b01, 32'h0, 1);
    // R13: sparse beats, each word one cycle after acceptance
    sect = "R13";
    for (int i = 0; i < 30; i++)
      step(i[0], 2'($urandom), 2'($urandom), $urandom, 1);
    // R3: random back-pressure with stalls
    sect = "R3";
    for (int i = 0; i < 1500; i++)
      step(($urandom % 4) != 0, 2'($urandom), 2'($urandom), $urandom, ($urandom % 3) != 0);
    sect = "R3 drain";
    for (int i = 0; i < 4; i++) step(0, 2'b00, 2'b00, 32'h0, 1);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule